// File: doc/BRIEF.md
# Write-Back LRU Fully Associative Cache

This block is a small data cache that sits between a processor and a line-wide memory. It has a single set, so a block of four words may live in any of its lines. A processor issues one word read or word write at a time and gets back a one-cycle response pulse. Read data comes with the pulse. A memory port moves a whole line per transaction and is used both to fetch missing lines and to write back dirty lines that are being replaced.

Stores go to the cache only, and the line is marked dirty. A store that misses first brings the line in, then writes the word into it. When a line has to be replaced, an invalid line is used if there is one. Otherwise the least recently used line is chosen, and it is written back in full first if it is dirty. On a miss, the processor sees no response until the whole line has arrived and the access has been looked up again. The line count, line width, word width and address width are parameters.

Top module: `wb_lru_cache`

## Requirements
- R1: A block may occupy any line, and at most one line ever matches a given block, so data written to or read from any block address is always returned correctly.
- R2: A line holds WORDS (default 4) words, and the low log2(WORDS) bits of the word address select the word. After a fill, the other words of that block hit without any memory traffic.
- R3: With every line valid, a miss replaces the line whose most recent access is oldest. Reads and writes both count as accesses.
- R4: A store hit changes only the cache. No memory transaction occurs, and later reads of that address return the stored value.
- R5: A store miss fetches the whole line and then writes the word. The line's other words keep their memory values.
- R6: On a miss, the response pulse comes only after the memory has returned the full line. A hit gives its response pulse exactly one cycle after the request is accepted.
- R7: After reset, the cache is empty, cpu_req_ready is 1, and cpu_resp_valid and mem_req_valid are 0. The first access to any block is a miss.
- R8: If the victim is dirty, its full line, including all stored words, is written to the victim's block address before the fill request for the new block is issued.
- R9: A memory request keeps valid, address and direction stable until it is accepted. Request addresses are line aligned, with the low log2(WORDS) bits at zero. A clean victim is never written back.
- R10: While any line is invalid, a miss fills an invalid line and evicts no valid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache idle and accepting a request |
| cpu_req_we | input | 1 | 1 = word write, 0 = word read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read data, valid with the pulse on reads |
| mem_req_valid | output | 1 | Line transaction request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_req_addr | output | ADDR_W | Line-aligned word address |
| mem_req_wline | output | DATA_W*WORDS | Write-back line data, word 0 in the low bits |
| mem_rsp_valid | input | 1 | Fetched line is present |
| mem_rsp_line | input | DATA_W*WORDS | Fetched line data, word 0 in the low bits |

## Verification
The bench keeps its own LRU-ordered model of which blocks are resident and which are dirty. It uses that model to predict, for every access, whether it hits and how many line fetches and write-backs it causes. It also predicts the address of any write-back. If the design aged lines wrongly, the bench would see a miss where it expects a hit. If it evicted a valid line while an invalid one was free, the bench would also see an unexpected miss. If it wrote back clean lines, or dropped dirty data, the write-back counts or the checked write-back contents would be wrong. A store miss that skipped allocation, or that overwrote the neighbouring words, would return wrong values when those words are read back. Hit latency is measured on every hit. A response given before the fill completes is caught by counting fetched lines at the moment of the response.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } cache_state_e;
endpackage

// File: rtl/cache_tags.sv
module cache_tags #(
  parameter int LINES = 4,
  parameter int TAG_W = 10,
  parameter int IDX_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [TAG_W-1:0]             lookup_tag,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  input  logic                         fill_en,
  input  logic [IDX_W-1:0]             fill_idx,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic                         mark_en,
  input  logic [IDX_W-1:0]             mark_idx,
  output logic [LINES-1:0]             valid_vec,
  output logic [LINES-1:0]             dirty_vec,
  output logic [LINES-1:0][TAG_W-1:0]  tag_vec
);
  logic [LINES-1:0][TAG_W-1:0] tag_q;
  logic [LINES-1:0]            valid_q, dirty_q, match_vec;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
      assign match_vec[g] = valid_q[g] && (tag_q[g] == lookup_tag);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (match_vec[i]) hit_idx = IDX_W'(i);
  end
  assign hit = |match_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;
      end
      if (mark_en) dirty_q[mark_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign valid_vec = valid_q;
  assign dirty_vec = dirty_q;
  assign tag_vec   = tag_q;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R1
  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]); // R5
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int LINES = 4,
  parameter int IDX_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         touch_en,
  input  logic [IDX_W-1:0]             touch_idx,
  output logic [LINES-1:0][IDX_W-1:0]  age_vec,
  output logic [IDX_W-1:0]             oldest_idx
);
  localparam int AGE_SUM = LINES * (LINES - 1) / 2;

  logic [LINES-1:0][IDX_W-1:0] age_q;
  int age_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (age_q[i] == IDX_W'(LINES - 1)) oldest_idx = IDX_W'(i);
  end

  always_comb begin
    age_sum = 0;
    for (int i = 0; i < LINES; i++) age_sum = age_sum + int'(age_q[i]);
  end

  assign age_vec = age_q;

  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
    age_sum == AGE_SUM); // R3
  AST_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> age_q[$past(touch_idx)] == '0); // R3
endmodule

// File: rtl/cache_data.sv
module cache_data #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic                     clk,
  input  logic                     fill_en,
  input  logic [IDX_W-1:0]         fill_idx,
  input  logic [DATA_W*WORDS-1:0]  fill_line,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [OFF_W-1:0]         wr_off,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic [OFF_W-1:0]         rd_off,
  output logic [DATA_W-1:0]        rd_word,
  input  logic [IDX_W-1:0]         line_idx,
  output logic [DATA_W*WORDS-1:0]  line_data
);
  logic [WORDS-1:0][DATA_W-1:0] lane_word;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
      logic [DATA_W-1:0] lane_mem [LINES];
      always_ff @(posedge clk) begin
        if (fill_en)
          lane_mem[fill_idx] <= fill_line[w*DATA_W +: DATA_W];
        else if (wr_en && (wr_off == OFF_W'(w)))
          lane_mem[wr_idx] <= wr_data;
      end
      assign lane_word[w]                   = lane_mem[rd_idx];
      assign line_data[w*DATA_W +: DATA_W]  = lane_mem[line_idx];
    end
  endgenerate

  assign rd_word = lane_word[rd_off];
endmodule

// File: rtl/wb_lru_cache.sv
module wb_lru_cache #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int LINES  = 4,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req_valid,
  output logic                     cpu_req_ready,
  input  logic                     cpu_req_we,
  input  logic [ADDR_W-1:0]        cpu_req_addr,
  input  logic [DATA_W-1:0]        cpu_req_wdata,
  output logic                     cpu_resp_valid,
  output logic [DATA_W-1:0]        cpu_resp_rdata,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_we,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [DATA_W*WORDS-1:0]  mem_req_wline,
  input  logic                     mem_rsp_valid,
  input  logic [DATA_W*WORDS-1:0]  mem_rsp_line
);
  import cache_pkg::*;

  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(LINES);

  cache_state_e state_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [IDX_W-1:0]  victim_q, victim_c;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_rdata_q;

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              hit, lookup, fill_en, store_hit;
  logic [IDX_W-1:0]  hit_idx, oldest_idx;
  logic [LINES-1:0]  valid_vec, dirty_vec;
  logic [LINES-1:0][TAG_W-1:0] tag_vec;
  logic [LINES-1:0][IDX_W-1:0] age_vec;
  logic [DATA_W-1:0] hit_word;

  assign req_tag   = req_addr_q[ADDR_W-1:OFF_W];
  assign req_off   = req_addr_q[OFF_W-1:0];
  assign lookup    = (state_q == ST_LOOKUP);
  assign store_hit = lookup && hit && req_we_q;
  assign fill_en   = (state_q == ST_FILL_WAIT) && mem_rsp_valid;

  always_comb begin
    victim_c = oldest_idx;
    if (!(&valid_vec)) begin
      for (int i = LINES - 1; i >= 0; i--)
        if (!valid_vec[i]) victim_c = IDX_W'(i);
    end
  end

  cache_tags #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst(rst), .lookup_tag(req_tag), .hit(hit), .hit_idx(hit_idx),
    .fill_en(fill_en), .fill_idx(victim_q), .fill_tag(req_tag),
    .mark_en(store_hit), .mark_idx(hit_idx),
    .valid_vec(valid_vec), .dirty_vec(dirty_vec), .tag_vec(tag_vec)
  );

  cache_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .touch_en(lookup && hit), .touch_idx(hit_idx),
    .age_vec(age_vec), .oldest_idx(oldest_idx)
  );

  cache_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk(clk), .fill_en(fill_en), .fill_idx(victim_q), .fill_line(mem_rsp_line),
    .wr_en(store_hit), .wr_idx(hit_idx), .wr_off(req_off), .wr_data(req_wdata_q),
    .rd_idx(hit_idx), .rd_off(req_off), .rd_word(hit_word),
    .line_idx(victim_q), .line_data(mem_req_wline)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      resp_valid_q <= 1'b0;
      resp_rdata_q <= '0;
      req_we_q     <= 1'b0;
      req_addr_q   <= '0;
      req_wdata_q  <= '0;
      victim_q     <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_req_valid) begin
          req_we_q    <= cpu_req_we;
          req_addr_q  <= cpu_req_addr;
          req_wdata_q <= cpu_req_wdata;
          state_q     <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            resp_valid_q <= 1'b1;
            if (!req_we_q) resp_rdata_q <= hit_word;
            state_q <= ST_IDLE;
          end else begin
            victim_q <= victim_c;
            state_q  <= (valid_vec[victim_c] && dirty_vec[victim_c]) ? ST_WB : ST_FILL_REQ;
          end
        end
        ST_WB:        if (mem_req_ready) state_q <= ST_FILL_REQ;
        ST_FILL_REQ:  if (mem_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) state_q <= ST_LOOKUP;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready  = (state_q == ST_IDLE);
  assign cpu_resp_valid = resp_valid_q;
  assign cpu_resp_rdata = resp_rdata_q;
  assign mem_req_valid  = (state_q == ST_WB) || (state_q == ST_FILL_REQ);
  assign mem_req_we     = (state_q == ST_WB);
  assign mem_req_addr   = (state_q == ST_WB) ? {tag_vec[victim_q], {OFF_W{1'b0}}}
                                             : {req_tag, {OFF_W{1'b0}}};

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R9
  AST_RESP_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |-> $past(hit) && $past(state_q) == ST_LOOKUP); // R6
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (rst)
    lookup && !hit && !(&valid_vec) |-> !valid_vec[victim_c]); // R10
  AST_VICTIM_OLDEST: assert property (@(posedge clk) disable iff (rst)
    lookup && !hit && (&valid_vec) |-> age_vec[victim_c] == IDX_W'(LINES - 1)); // R3
  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FILL_REQ && $past(state_q) == ST_LOOKUP |-> !(valid_vec[victim_q] && dirty_vec[victim_q])); // R8
endmodule

// File: tb/tb_wb_lru_cache.sv
`timescale 1ns/1ps
module tb_wb_lru_cache;
  localparam int DW = 32, AW = 8, NL = 4, NW = 4, LW = DW * NW;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic cpu_req_valid, cpu_req_ready, cpu_req_we, cpu_resp_valid;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata, cpu_resp_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [LW-1:0] mem_req_wline, mem_rsp_line;

  wb_lru_cache #(.DATA_W(DW), .ADDR_W(AW), .LINES(NL), .WORDS(NW)) dut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wline(mem_req_wline),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
  );

  logic [DW-1:0] mem [MSZ];
  logic [DW-1:0] golden [MSZ];
  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, fill_cnt = 0, last_wb_addr = -1;
  int mblk [NL];
  bit mdirty [NL];
  int mcount = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: variable accept stall, fetched line returned 3 cycles after accept
  int stall = 0, stall_len = 0, rd_dly = 0;
  bit rd_pend = 0;
  logic [AW-1:0] rd_addr;
  always @(posedge clk) begin
    if (rst) begin
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; rd_pend <= 1'b0; stall <= 0;
      mem_rsp_line <= '0;
    end else begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        stall <= 0;
        stall_len <= (stall_len + 1) % 3;
        check(mem_req_addr[1:0] == 2'b00, "R9", "aligned request", 32'(mem_req_addr), 32'(mem_req_addr) & ~32'd3);
        if (mem_req_we) begin
          wr_cnt++;
          last_wb_addr = int'(mem_req_addr);
          for (int w = 0; w < NW; w++) begin
            check(mem_req_wline[w*DW +: DW] == golden[int'(mem_req_addr) + w], "R8", "write-back word",
                  mem_req_wline[w*DW +: DW], golden[int'(mem_req_addr) + w]);
            mem[int'(mem_req_addr) + w] = mem_req_wline[w*DW +: DW];
          end
        end else begin
          rd_cnt++;
          rd_pend <= 1'b1;
          rd_dly  <= 2;
          rd_addr <= mem_req_addr;
        end
      end else if (mem_req_valid) begin
        if (stall >= stall_len) mem_req_ready <= 1'b1;
        else stall <= stall + 1;
      end
      if (rd_pend) begin
        if (rd_dly == 0) begin
          for (int w = 0; w < NW; w++) mem_rsp_line[w*DW +: DW] <= mem[int'(rd_addr) + w];
          mem_rsp_valid <= 1'b1;
          rd_pend <= 1'b0;
          fill_cnt++;
        end else rd_dly <= rd_dly - 1;
      end
    end
  end

  task automatic access(bit we, int addr, logic [DW-1:0] wd, string req);
    int blk, pos, r0, w0, f0, n, tb, exp_wb, exp_wb_blk;
    bit td, exp_hit;
    blk = addr / NW;
    pos = -1;
    for (int i = 0; i < mcount; i++) if (mblk[i] == blk) pos = i;
    exp_hit = (pos >= 0);
    exp_wb = 0; exp_wb_blk = -1;
    if (exp_hit) begin
      tb = mblk[pos]; td = mdirty[pos];
      for (int i = pos; i > 0; i--) begin mblk[i] = mblk[i-1]; mdirty[i] = mdirty[i-1]; end
      mblk[0] = tb; mdirty[0] = td;
    end else begin
      if (mcount < NL) begin
        for (int i = mcount; i > 0; i--) begin mblk[i] = mblk[i-1]; mdirty[i] = mdirty[i-1]; end
        mcount++;
      end else begin
        exp_wb = mdirty[NL-1] ? 1 : 0;
        exp_wb_blk = mblk[NL-1];
        for (int i = NL - 1; i > 0; i--) begin mblk[i] = mblk[i-1]; mdirty[i] = mdirty[i-1]; end
      end
      mblk[0] = blk; mdirty[0] = 1'b0;
    end
    if (we) mdirty[0] = 1'b1;

    r0 = rd_cnt; w0 = wr_cnt; f0 = fill_cnt;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = AW'(addr); cpu_req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    n = 1;
    while (!cpu_resp_valid) begin @(negedge clk); n++; end

    if (!we) check(cpu_resp_rdata == golden[addr], req, "read data", cpu_resp_rdata, golden[addr]);
    else golden[addr] = wd;
    check((rd_cnt - r0) == (exp_hit ? 0 : 1), req, "line fetches", 32'(rd_cnt - r0), exp_hit ? 0 : 1);
    check((fill_cnt - f0) == (exp_hit ? 0 : 1), "R6", "line received before response", 32'(fill_cnt - f0), exp_hit ? 0 : 1);
    check((wr_cnt - w0) == exp_wb, "R9", "write-backs (clean victims none)", 32'(wr_cnt - w0), 32'(exp_wb));
    if (exp_hit) check(n == 2, "R6", "hit latency", 32'(n), 2);
    if (exp_wb != 0) check(last_wb_addr == exp_wb_blk * NW, "R8", "write-back address", 32'(last_wb_addr), 32'(exp_wb_blk * NW));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    int a;
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 32'h5a5a0000 ^ (32'(i) * 32'h01010101);
      golden[i] = mem[i];
    end
    rst = 1'b1; cpu_req_valid = 1'b0; cpu_req_we = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R7", "ready after reset", 32'(cpu_req_ready), 1);
    check(cpu_resp_valid == 1'b0, "R7", "no response after reset", 32'(cpu_resp_valid), 0);
    check(mem_req_valid == 1'b0, "R7", "no memory request after reset", 32'(mem_req_valid), 0);

    // R7 / R10: first touches miss and fill free lines
    access(0, 'h00, '0, "R7"); access(0, 'h10, '0, "R10");
    access(0, 'h20, '0, "R10"); access(0, 'h30, '0, "R10");
    // R2: other words of filled lines hit
    access(0, 'h01, '0, "R2"); access(0, 'h12, '0, "R2");
    access(0, 'h23, '0, "R2"); access(0, 'h33, '0, "R2");
    // R4: store hits stay in cache
    access(1, 'h02, 32'hAAAA0002, "R4"); access(1, 'h11, 32'hBBBB0011, "R4");
    access(0, 'h02, '0, "R4"); access(0, 'h11, '0, "R4");
    // R3: full cache, LRU eviction and re-miss of evicted block
    access(0, 'h40, '0, "R3"); access(0, 'h20, '0, "R3");
    access(0, 'h10, '0, "R3"); access(0, 'h30, '0, "R3");
    // R8: dirty victims written back before fill
    access(0, 'h50, '0, "R8"); access(0, 'h60, '0, "R8");
    access(0, 'h02, '0, "R8"); access(0, 'h11, '0, "R8");
    // R5: store miss allocates, neighbours keep memory values
    access(1, 'h71, 32'hC0DE0071, "R5");
    access(0, 'h70, '0, "R5"); access(0, 'h72, '0, "R5");
    access(0, 'h73, '0, "R5"); access(0, 'h71, '0, "R5");
    // R1: sweep of mixed reads and writes over ten blocks spread across the address space
    seed = 32'h1234_5678;
    for (int k = 0; k < 600; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      a = int'((seed >> 8) % 10) * 24 + int'(seed % 4);
      access(seed[20], a, seed ^ 32'hF00D_0000, "R1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule